// File: doc/BRIEF.md
# Boot Flash Top-Swap Address Decoder

This block turns host memory addresses near the top of the 32-bit space into byte offsets inside a boot flash device. The flash image sits at the highest addresses, so its last byte answers at host address 0xFFFFFFFF. The block raises an in-range flag only for addresses that fall inside that window.

A single swap bit chooses between two mappings. With the bit clear, the mapping is direct. With the bit set, the two highest boot-block-sized regions of the flash trade places. At reset the processor then fetches a backup boot block from the region just below the normal one. The boot-block size is selectable, and the pair of exchanged regions follows it.

The swap bit sits in a battery-backed domain. Only that domain's own reset clears it, and the ordinary system reset leaves it alone. Software reaches the bit through a small register port that writes and reads it.

Top module: `boot_topswap_decoder`

## Requirements
- R1: With the swap bit at 0, every in-range address maps to offset = host address modulo FLASH_BYTES (default 2 MiB), e.g. 0xFFFF1234 -> 0x1F1234 and 0xFFFE0010 -> 0x1E0010.
- R2: With the swap bit at 1 and a 64 KiB block (size_sel = 2'b00), host bit 16 is inverted inside the top two 64 KiB blocks: 0xFFFF1234 -> 0x1E1234 and 0xFFFE0010 -> 0x1F0010. Address bits 15:0 are never altered.
- R3: flash_hit is 1 only when the access was valid and the host address lies in the top FLASH_BYTES of the 4 GiB space. For the default size that means host bits 31:21 are all ones. Otherwise flash_hit is 0.
- R4: size_sel picks the exchanged block size and the inverted bit: 2'b00 = 64 KiB (bit 16), 2'b01 = 128 KiB (bit 17), 2'b10 = 256 KiB (bit 18), and 2'b11 (reserved) behaves as 2'b00. With a 256 KiB block and swap set, 0xFFFC0000 -> 0x180000 and 0xFFF80000 -> 0x1C0000.
- R5: In-range addresses outside the top two blocks of the selected size map directly, whatever the swap bit holds.
- R6: When swap_we is 1 at a clock edge, the swap bit takes the value of swap_wdata. swap_rdata always shows the current bit. An access presented in the cycle after the write uses the new value.
- R7: The swap bit keeps its value through the system reset rst and is cleared to 0 only by the power-well reset pw_rst.
- R8: With REG_OUT = 1 (default), flash_offset, flash_hit and flash_valid reflect the access presented one clock earlier, and rst clears flash_valid and flash_hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, synchronous, active high; does not touch the swap bit |
| pw_rst | input | 1 | Battery-well reset, synchronous, active high; clears the swap bit |
| host_addr | input | 32 | Host byte address |
| host_valid | input | 1 | Host address strobe |
| size_sel | input | 2 | Boot-block size select (00 64K, 01 128K, 10 256K, 11 as 00) |
| swap_we | input | 1 | Write strobe for the swap bit |
| swap_wdata | input | 1 | Value written to the swap bit |
| swap_rdata | output | 1 | Current swap bit |
| flash_offset | output | FLASH_AW (21) | Byte offset inside the flash |
| flash_hit | output | 1 | Valid access inside the flash window |
| flash_valid | output | 1 | Output qualifier, follows host_valid |

## Verification
Several properties are checked on every cycle: the swap bit's write and hold behaviour, including its immunity to the system reset; the hit flag never rising without a valid access; the direct mapping when the swap bit is clear or the address lies below the top 512 KiB; and the inversion of bit 16 or bit 18 for the 64 KiB and 256 KiB selects. Only the bench scenarios can show some other things. These are the exact offsets across the whole window for every size select, including the reserved code, and the exact window edge of the hit flag. They also include the ordering of a register write against the access that follows it, and the clearing of the swap bit by the power-well reset.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    localparam int unsigned HOST_AW = 32;

    typedef enum logic [1:0] {
        BLK_64K  = 2'b00,
        BLK_128K = 2'b01,
        BLK_256K = 2'b10,
        BLK_RSVD = 2'b11
    } blk_size_e;

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic [HOST_AW-1:0] addr;   // host address after any swap
    } xlate_t;

    // Bit index that separates the two exchanged regions
    function automatic logic [4:0] blk_shift(blk_size_e s);
        case (s)
            BLK_128K: return 5'd17;
            BLK_256K: return 5'd18;
            default:  return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/tsw_swap_cell.sv
module tsw_swap_cell (
    input  logic clk,
    input  logic pw_rst,
    input  logic we,
    input  logic wdata,
    output logic q
);
    always_ff @(posedge clk) begin
        if (pw_rst)
            q <= 1'b0;
        else if (we)
            q <= wdata;
    end

    AST_SWAP_WRITE: assert property (@(posedge clk) disable iff (pw_rst)
        we |=> (q == $past(wdata))) else $error("swap write lost"); // R6

    AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (pw_rst)
        !we |=> $stable(q)) else $error("swap bit changed without write"); // R7
endmodule

// File: rtl/tsw_xlate.sv
module tsw_xlate
    import tsw_pkg::*;
#(
    parameter int unsigned FLASH_AW = 21
) (
    input  logic               [HOST_AW-1:0] host_addr,
    input  logic                             host_valid,
    input  logic                             swap,
    input  blk_size_e                        size,
    output xlate_t                           res
);
    localparam int unsigned WIN_HI_W = HOST_AW - FLASH_AW;

    generate
        if (FLASH_AW < 19) begin : g_bad_size
            $error("flash must hold two 256 KiB blocks");
        end
    endgenerate

    logic [4:0]         sh;
    logic [HOST_AW-1:0] hi_part;
    logic [HOST_AW-1:0] hi_ones;
    logic               in_pair;
    logic               in_window;
    logic               flip;

    always_comb begin
        sh        = blk_shift(size);
        hi_part   = host_addr >> (sh + 5'd1);
        hi_ones   = {HOST_AW{1'b1}} >> (sh + 5'd1);
        in_pair   = (hi_part == hi_ones);
        in_window = &host_addr[HOST_AW-1 -: WIN_HI_W];
        flip      = swap & in_pair & in_window;

        res.valid = host_valid;
        res.hit   = host_valid & in_window;
        res.addr  = host_addr ^ ({{(HOST_AW-1){1'b0}}, flip} << sh);
    end
endmodule

// File: rtl/tsw_out_stage.sv
module tsw_out_stage
    import tsw_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  xlate_t d,
    output xlate_t q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    q.valid <= 1'b0;
                    q.hit   <= 1'b0;
                    q.addr  <= '0;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/boot_topswap_decoder.sv
module boot_topswap_decoder
    import tsw_pkg::*;
#(
    parameter int unsigned FLASH_BYTES = 2097152,
    parameter bit          REG_OUT     = 1'b1,
    localparam int unsigned FLASH_AW   = $clog2(FLASH_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pw_rst,
    input  logic [31:0]         host_addr,
    input  logic                host_valid,
    input  logic [1:0]          size_sel,
    input  logic                swap_we,
    input  logic                swap_wdata,
    output logic                swap_rdata,
    output logic [FLASH_AW-1:0] flash_offset,
    output logic                flash_hit,
    output logic                flash_valid
);
    logic   swap_q;
    xlate_t xl_d;
    xlate_t xl_q;

    tsw_swap_cell u_swap (
        .clk    (clk),
        .pw_rst (pw_rst),
        .we     (swap_we),
        .wdata  (swap_wdata),
        .q      (swap_q)
    );

    tsw_xlate #(.FLASH_AW(FLASH_AW)) u_xlate (
        .host_addr  (host_addr),
        .host_valid (host_valid),
        .swap       (swap_q),
        .size       (blk_size_e'(size_sel)),
        .res        (xl_d)
    );

    tsw_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (xl_d),
        .q   (xl_q)
    );

    assign swap_rdata   = swap_q;
    assign flash_offset = xl_q.addr[FLASH_AW-1:0];
    assign flash_hit    = xl_q.hit;
    assign flash_valid  = xl_q.valid;

    generate
        if (REG_OUT) begin : g_chk
            AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst || pw_rst)
                flash_hit |-> flash_valid) else $error("hit without valid"); // R3

            AST_DIRECT_NO_SWAP: assert property (@(posedge clk) disable iff (rst || pw_rst)
                (flash_valid && !$past(swap_rdata)) |-> (flash_offset == $past(host_addr[FLASH_AW-1:0])))
                else $error("direct map broken"); // R1

            AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (rst || pw_rst)
                flash_valid |-> (flash_offset[15:0] == $past(host_addr[15:0])))
                else $error("low bits altered"); // R2

            AST_BELOW_PAIR_DIRECT: assert property (@(posedge clk) disable iff (rst || pw_rst)
                (flash_valid && !$past(&host_addr[31:19])) |-> (flash_offset == $past(host_addr[FLASH_AW-1:0])))
                else $error("address below pair remapped"); // R5

            AST_SWAP_64K_BIT16: assert property (@(posedge clk) disable iff (rst || pw_rst)
                (flash_valid && $past(swap_rdata) && ($past(size_sel) == 2'b00) && $past(&host_addr[31:17]))
                |-> (flash_offset[16] != $past(host_addr[16])))
                else $error("64K swap bit wrong"); // R2

            AST_SWAP_256K_BIT18: assert property (@(posedge clk) disable iff (rst || pw_rst)
                (flash_valid && $past(swap_rdata) && ($past(size_sel) == 2'b10) && $past(&host_addr[31:19]))
                |-> (flash_offset[18] != $past(host_addr[18])))
                else $error("256K swap bit wrong"); // R4
        end
    endgenerate
endmodule

// File: tb/sim_boot_topswap_decoder.sv
module sim_boot_topswap_decoder;
    localparam int CLK_PERIOD  = 10;
    localparam int FLASH_BYTES = 2097152;
    localparam int FLASH_AW    = 21;

    logic                clk = 1'b0;
    logic                rst;
    logic                pw_rst;
    logic [31:0]         host_addr;
    logic                host_valid;
    logic [1:0]          size_sel;
    logic                swap_we;
    logic                swap_wdata;
    logic                swap_rdata;
    logic [FLASH_AW-1:0] flash_offset;
    logic                flash_hit;
    logic                flash_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_topswap_decoder #(.FLASH_BYTES(FLASH_BYTES)) u0 (
        .clk(clk), .rst(rst), .pw_rst(pw_rst),
        .host_addr(host_addr), .host_valid(host_valid), .size_sel(size_sel),
        .swap_we(swap_we), .swap_wdata(swap_wdata), .swap_rdata(swap_rdata),
        .flash_offset(flash_offset), .flash_hit(flash_hit), .flash_valid(flash_valid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // presents one access, then waits until its registered result is visible
    task automatic access(input logic [31:0] a, input logic v);
        @(negedge clk);
        host_addr  = a;
        host_valid = v;
        @(negedge clk);
    endtask

    task automatic write_swap(input logic val);
        @(negedge clk);
        swap_we    = 1'b1;
        swap_wdata = val;
        @(negedge clk);
        swap_we    = 1'b0;
    endtask

    function automatic longint exp_offset(input logic [31:0] a, input bit sw, input int sel);
        longint blk, base, x;
        blk  = (sel == 1) ? 131072 : (sel == 2) ? 262144 : 65536;
        base = 64'h1_0000_0000 - 2*blk;
        x    = a;
        if (sw && x >= base) begin
            if (x - base < blk) x = x + blk;
            else                x = x - blk;
        end
        return x % FLASH_BYTES;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; pw_rst = 1'b1;
        host_addr = 32'h0; host_valid = 1'b0; size_sel = 2'b00;
        swap_we = 1'b0; swap_wdata = 1'b0;
        repeat (3) @(negedge clk);
        check(swap_rdata == 1'b0, "R7 swap after pw_rst", swap_rdata, 0);
        check(flash_valid == 1'b0 && flash_hit == 1'b0, "R8 outputs in reset", {flash_valid, flash_hit}, 0);
        rst = 1'b0; pw_rst = 1'b0;

        // Directed examples
        access(32'hFFFF1234, 1'b1);
        check(flash_offset == 21'h1F1234, "R1 direct top", flash_offset, 21'h1F1234);
        check(flash_hit == 1'b1 && flash_valid == 1'b1, "R8 one-cycle result", flash_hit, 1);
        access(32'hFFFE0010, 1'b1);
        check(flash_offset == 21'h1E0010, "R1 direct second block", flash_offset, 21'h1E0010);

        // R6: write then immediate next-cycle access
        @(negedge clk);
        swap_we = 1'b1; swap_wdata = 1'b1;
        @(negedge clk);
        swap_we = 1'b0;
        host_addr = 32'hFFFF1234; host_valid = 1'b1;
        check(swap_rdata == 1'b1, "R6 readback", swap_rdata, 1);
        @(negedge clk);
        check(flash_offset == 21'h1E1234, "R6 new value used by next access", flash_offset, 21'h1E1234);
        access(32'hFFFE0010, 1'b1);
        check(flash_offset == 21'h1F0010, "R2 swapped second block", flash_offset, 21'h1F0010);

        // R4: 256K and reserved select
        size_sel = 2'b10;
        access(32'hFFFC0000, 1'b1);
        check(flash_offset == 21'h180000, "R4 256K upper", flash_offset, 21'h180000);
        access(32'hFFF80000, 1'b1);
        check(flash_offset == 21'h1C0000, "R4 256K lower", flash_offset, 21'h1C0000);
        size_sel = 2'b11;
        access(32'hFFFF0000, 1'b1);
        check(flash_offset == 21'h1E0000, "R4 reserved as 64K", flash_offset, 21'h1E0000);
        size_sel = 2'b00;

        // R3: invalid strobe and out-of-range address
        access(32'hFFFF0000, 1'b0);
        check(flash_hit == 1'b0 && flash_valid == 1'b0, "R3 no hit without valid", flash_hit, 0);
        access(32'hFFDFFFFF, 1'b1);
        check(flash_hit == 1'b0, "R3 just below window", flash_hit, 0);
        access(32'hFFE00000, 1'b1);
        check(flash_hit == 1'b1 && flash_offset == 21'h0, "R3 window base", flash_offset, 0);

        // R7: system reset keeps swap; pw_rst clears it
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(flash_valid == 1'b0, "R8 rst clears outputs", flash_valid, 0);
        rst = 1'b0;
        check(swap_rdata == 1'b1, "R7 swap survives rst", swap_rdata, 1);
        access(32'hFFFF0000, 1'b1);
        check(flash_offset == 21'h1E0000, "R7 swap active after rst", flash_offset, 21'h1E0000);
        @(negedge clk); pw_rst = 1'b1;
        @(negedge clk); pw_rst = 1'b0;
        check(swap_rdata == 1'b0, "R7 pw_rst clears swap", swap_rdata, 0);

        // Sweep over swap value, size select and 4 MiB below the top
        for (int sw = 0; sw < 2; sw++) begin
            write_swap(sw[0]);
            for (int sel = 0; sel < 4; sel++) begin
                size_sel = sel[1:0];
                for (int i = 0; i < 512; i++) begin
                    logic [31:0] a;
                    longint      eo;
                    bit          eh;
                    string       tag;
                    a  = 32'hFFC00000 + i * 32'h2000 + ((i * 113) & 32'h1FFF);
                    eo = exp_offset(a, sw[0], sel);
                    eh = (a >= 32'hFFE00000);
                    access(a, 1'b1);
                    if (!eh)                       tag = "R3 sweep out of window";
                    else if (sw == 0)              tag = "R1 sweep direct";
                    else if (eo != (a % FLASH_BYTES)) tag = (sel == 0) ? "R2 sweep swapped" : "R4 sweep swapped";
                    else                           tag = "R5 sweep pass-through";
                    check(flash_hit == eh, tag, flash_hit, eh);
                    if (eh) check(flash_offset == eo[FLASH_AW-1:0], tag, flash_offset, eo);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule